// File: doc/BRIEF.md
# Buffered modulus timer counter

This block is the counting engine of one timer channel. A 16-bit counter steps between 1 and an active period value. It runs either as a sawtooth up counter or as a triangle up/down counter. Software sets the period through a staging register. The active period takes the staged value only when a counting cycle ends, so a period change never cuts a cycle short.

Each count step is caused by a tick. A tick is either a single-cycle enable from an external prescaler or an edge on an input pin. The pin passes through a synchronizer and an edge detector, and the active edge can be chosen. At the end of every counting cycle the block sets a sticky flag, which software clears by writing 1.

A run bit gates counting. While the channel is stopped, software may preload the counter and may write the period directly. If the counter starts outside the legal range, it climbs to the top of its range and wraps to 1 before normal counting resumes.

Top module: `bmt_timer`

## Requirements
- R1: After reset the count reads 1 and the flag reads 0. The channel is stopped, in up mode, with the internal tick source and rising edge selected. The active and staged periods both hold RESET_PERIOD (default 16).
- R2: Register map, selected by `wr_addr` and taking effect at the clock edge where `wr_en` is high. Address 0 is the staged period. Address 1 is control: bit 0 run, bit 1 up/down mode, bit 2 external tick source, bit 3 both edges, bit 4 falling edge. Address 2 clears the flag when data bit 0 is 1. Address 3 preloads the counter.
- R3: In up mode each tick adds 1. A tick while the count equals the active period sets the count to 1, so with continuous ticks the period is P ticks.
- R4: In up/down mode the counter climbs to P and then descends. The tick that brings it down to 1 turns it upward again, so the period is 2*P-2 ticks, including P=2.
- R5: The end of a cycle is the tick that sets the count to 1 from P (up mode) or from the descent (up/down mode). Only this event copies the staged period into the active period. A staged write made during a cycle governs the following cycle.
- R6: The flag becomes 1 at the same clock edge where the count becomes 1 at the end of a cycle. Writing 1 to bit 0 at address 2 clears it. If the flag is set and cleared in the same cycle, the set wins.
- R7: If the count lies outside 1..P, no period match happens. The counter climbs to 0xFFFF and wraps to 1 on the next tick. This wrap neither sets the flag nor loads the period.
- R8: With the external source selected, `tick_int` has no effect. A pin change made before rising edge k is reflected in the count at edge k+2.
- R9: The external edge select is one of rising, falling, or both edges. Edges of the other kind have no effect on the count.
- R10: While stopped, ticks do not change the count, a preload sets the count and the direction up, and a staged period write also sets the active period. While running, preload writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| tick_int | input | 1 | Prescaled internal tick enable |
| ext_pin | input | 1 | External tick pin, asynchronous |
| count | output | 16 | Current counter value |
| flag | output | 1 | Sticky end-of-cycle flag |

## Verification
The counting is driven in four ways:
- Continuous internal ticks in up mode with periods 16, 5 and 3 tell the sawtooth apart from an off-by-one period and show the staged period taking effect one cycle late.
- Up/down runs with periods 3 and 2 separate the 2*P-2 triangle from the sawtooth, including the degenerate turn at the bottom.
- An out-of-range preload shows the wrap through 0xFFFF without a flag.
- Pin toggles under each edge selection separate rising, falling and both-edge detection and expose the synchronizer latency.

A behavioural model in the bench predicts the count and flag on every clock.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

  typedef enum logic [1:0] {
    SEL_STAGE = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_FLAG  = 2'd2,
    SEL_LOAD  = 2'd3
  } reg_sel_e;

  // control register fields, bit 0 at the bottom
  typedef struct packed {
    logic falling;
    logic both;
    logic ext;
    logic updown;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/bmt_tick_gen.sv
module bmt_tick_gen
  import bmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ext_pin,
  input  logic  tick_int,
  input  ctrl_t ctrl,
  output logic  tick
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   rise, fall, pin_edge;

  always_comb begin
    sync_d[0] = ext_pin;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise = sync_q[LAST] & ~prev_q;
    fall = ~sync_q[LAST] & prev_q;
    if (ctrl.both) begin
      pin_edge = rise | fall;
    end else if (ctrl.falling) begin
      pin_edge = fall;
    end else begin
      pin_edge = rise;
    end
    tick = ctrl.run & (ctrl.ext ? pin_edge : tick_int);
  end

  // R9: an edge detector output lasts at most one cycle per pin transition
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/bmt_regs.sv
module bmt_regs
  import bmt_pkg::*;
#(
  parameter int W            = 16,
  parameter int RESET_PERIOD = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         boundary,
  output ctrl_t        ctrl,
  output logic [W-1:0] period,
  output logic         flag
);

  localparam logic [W-1:0] PERIOD_RST = W'(RESET_PERIOD);

  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] period_q, period_d;
  ctrl_t        ctrl_q, ctrl_d;
  logic         flag_q, flag_d;
  logic         wr_stage, wr_ctrl, wr_clr;

  always_comb begin
    wr_stage = wr_en && (wr_sel == SEL_STAGE);
    wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
    wr_clr   = wr_en && (wr_sel == SEL_FLAG) && wr_data[0];

    stage_d  = wr_stage ? wr_data : stage_q;

    period_d = period_q;
    if (boundary) begin
      period_d = stage_q;
    end else if (wr_stage && !ctrl_q.run) begin
      period_d = wr_data;
    end

    ctrl_d = wr_ctrl ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;

    flag_d = flag_q;
    if (boundary) begin
      flag_d = 1'b1;
    end else if (wr_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= PERIOD_RST;
      period_q <= PERIOD_RST;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      period_q <= period_d;
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign period = period_q;
  assign flag   = flag_q;

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> flag_q);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !boundary) |=> !flag_q);

  assert_period_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && !boundary) |=> $stable(period_q));

  assert_period_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (period_q == $past(stage_q)));

endmodule

// File: rtl/bmt_counter.sv
module bmt_counter
  import bmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         updown,
  input  logic [W-1:0] period,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         boundary
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] TWO  = W'(2);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q, cnt_d;
  dir_e         dir_q, dir_d;
  logic         at_top, at_max, descend;

  always_comb begin
    at_top   = (cnt_q == period);
    at_max   = (cnt_q == MAXV);
    descend  = updown && ((dir_q == DIR_DOWN) || at_top);
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    boundary = 1'b0;
    if (load_en) begin
      cnt_d = load_val;
      dir_d = DIR_UP;
    end else begin
      if (!updown) begin
        dir_d = DIR_UP;
      end
      if (tick) begin
        if (!updown && at_top) begin
          cnt_d    = ONE;
          boundary = 1'b1;
        end else if (descend) begin
          if (cnt_q <= TWO) begin
            cnt_d    = ONE;
            dir_d    = DIR_UP;
            boundary = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
            dir_d = DIR_DOWN;
          end
        end else if (at_max) begin
          cnt_d = ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count = cnt_q;

  assert_up_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !updown && !load_en && (count == period)) |=> (count == ONE));

  assert_descend_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_DOWN) |-> (cnt_q >= TWO));

  assert_boundary_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (count == ONE));

  assert_wrap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && (count == MAXV) && (period != MAXV)) |=> (count == ONE));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> $stable(count));

endmodule

// File: rtl/bmt_timer.sv
module bmt_timer
  import bmt_pkg::*;
#(
  parameter int W            = 16,
  parameter int RESET_PERIOD = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         tick_int,
  input  logic         ext_pin,
  output logic [W-1:0] count,
  output logic         flag
);

  reg_sel_e     wr_sel;
  ctrl_t        ctrl;
  logic [W-1:0] period;
  logic         tick, boundary, load_en;

  assign wr_sel  = reg_sel_e'(wr_addr);
  assign load_en = wr_en && (wr_sel == SEL_LOAD) && !ctrl.run;

  bmt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_pin  (ext_pin),
    .tick_int (tick_int),
    .ctrl     (ctrl),
    .tick     (tick)
  );

  bmt_regs #(.W(W), .RESET_PERIOD(RESET_PERIOD)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .boundary (boundary),
    .ctrl     (ctrl),
    .period   (period),
    .flag     (flag)
  );

  bmt_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .updown   (ctrl.updown),
    .period   (period),
    .load_en  (load_en),
    .load_val (wr_data),
    .count    (count),
    .boundary (boundary)
  );

  // R10: a stopped channel ignores ticks
  assert_stopped_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !(wr_en && (wr_sel == SEL_LOAD))) |=> $stable(count));

endmodule

// File: tb/bmt_timer_bench.sv
module bmt_timer_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        tick_int = 1'b0;
  logic        ext_pin = 1'b0;
  logic [15:0] count;
  logic        flag;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bmt_timer u_bmt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_int(tick_int), .ext_pin(ext_pin),
    .count(count), .flag(flag)
  );

  // behavioural reference model
  int m_cnt, m_a1, m_a2, nc, na1, na2;
  bit m_down, m_flag, nd, nf, bnd, tk, pe, lvl;
  bit m_s1, m_s2, m_prev;
  bit [4:0] m_ctrl, nctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 1; m_down = 0; m_a1 = 16; m_a2 = 16; m_flag = 0; m_ctrl = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      lvl = m_s2;
      if (m_ctrl[3]) pe = (lvl != m_prev);
      else if (m_ctrl[4]) pe = (!lvl && m_prev);
      else pe = (lvl && !m_prev);
      tk = m_ctrl[0] && (m_ctrl[2] ? pe : tick_int);
      bnd = 0; nc = m_cnt; nd = m_down;
      if (wr_en && wr_addr == 2'd3 && !m_ctrl[0]) begin
        nc = int'(wr_data); nd = 0;
      end else begin
        if (!m_ctrl[1]) nd = 0;
        if (tk) begin
          if (m_ctrl[1] && (m_down || m_cnt == m_a1)) begin
            if (m_cnt - 1 <= 1) begin nc = 1; nd = 0; bnd = 1; end
            else begin nc = m_cnt - 1; nd = 1; end
          end else if (!m_ctrl[1] && m_cnt == m_a1) begin
            nc = 1; bnd = 1;
          end else begin
            nc = (m_cnt >= 65535) ? 1 : m_cnt + 1;
          end
        end
      end
      na2 = (wr_en && wr_addr == 2'd0) ? int'(wr_data) : m_a2;
      na1 = bnd ? m_a2 : ((wr_en && wr_addr == 2'd0 && !m_ctrl[0]) ? int'(wr_data) : m_a1);
      nctl = (wr_en && wr_addr == 2'd1) ? wr_data[4:0] : m_ctrl;
      nf = bnd ? 1'b1 : ((wr_en && wr_addr == 2'd2 && wr_data[0]) ? 1'b0 : m_flag);
      m_cnt = nc; m_down = nd; m_a1 = na1; m_a2 = na2; m_ctrl = nctl; m_flag = nf;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the model a quarter period after every edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && !done) begin
        chk({cur_req, " model count"}, int'(count), m_cnt);
        chk({cur_req, " model flag"}, int'(flag), int'(m_flag));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_int = 1'b1;
    repeat (n) @(negedge clk);
    tick_int = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and default period
    cur_req = "R1";
    chk("R1 reset count", int'(count), 1);
    chk("R1 reset flag", int'(flag), 0);
    ticks(3);
    chk("R1 stopped after reset", int'(count), 1);
    wr(2'd1, 16'h0001);
    ticks(15);
    chk("R1 default period top", int'(count), 16);
    ticks(1);
    chk("R1 default period wrap", int'(count), 1);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0001);

    // R3 up mode, R2 register map, R10 direct period write while stopped
    cur_req = "R3";
    wr(2'd0, 16'd5);
    wr(2'd3, 16'd1);
    wr(2'd1, 16'h0001);
    ticks(4);
    chk("R3 count at period", int'(count), 5);
    chk("R6 flag before end", int'(flag), 0);
    ticks(1);
    chk("R3 back to one", int'(count), 1);
    chk("R6 flag at end", int'(flag), 1);
    wr(2'd2, 16'h0001);
    chk("R6 flag cleared", int'(flag), 0);

    // R5 staged period takes effect next cycle
    cur_req = "R5";
    wr(2'd0, 16'd3);
    ticks(2);
    chk("R5 old period still active", int'(count), 3);
    ticks(2);
    chk("R5 old period top", int'(count), 5);
    ticks(1);
    chk("R5 boundary", int'(count), 1);
    ticks(3);
    chk("R5 new period wrap", int'(count), 1);

    // R6 set wins over clear
    cur_req = "R6";
    wr(2'd2, 16'h0001);
    ticks(2);
    chk("R6 count before", int'(count), 3);
    tick_int = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0001;
    @(negedge clk);
    tick_int = 1'b0; wr_en = 1'b0;
    chk("R6 set beats clear", int'(flag), 1);
    wr(2'd2, 16'h0001);
    chk("R6 clear after", int'(flag), 0);

    // R4 up/down, period 3 then 2
    cur_req = "R4";
    wr(2'd1, 16'h0003);
    ticks(2);
    chk("R4 climb", int'(count), 3);
    ticks(1);
    chk("R4 descend", int'(count), 2);
    chk("R4 no flag mid", int'(flag), 0);
    ticks(1);
    chk("R4 bottom", int'(count), 1);
    chk("R4 flag at bottom", int'(flag), 1);
    wr(2'd0, 16'd2);
    ticks(4);
    chk("R4 period 3 again", int'(count), 1);
    wr(2'd2, 16'h0001);
    ticks(1);
    chk("R4 p2 top", int'(count), 2);
    ticks(1);
    chk("R4 p2 bottom", int'(count), 1);
    chk("R4 p2 flag", int'(flag), 1);

    // R7 out-of-range wrap
    cur_req = "R7";
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'd4);
    wr(2'd3, 16'hFFFD);
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h0001);
    ticks(2);
    chk("R7 reaches max", int'(count), 16'hFFFF);
    ticks(1);
    chk("R7 wraps to one", int'(count), 1);
    chk("R7 no flag on wrap", int'(flag), 0);
    ticks(4);
    chk("R7 normal after wrap", int'(count), 1);
    chk("R7 flag after normal", int'(flag), 1);

    // R10 stop gating and preload rules
    cur_req = "R10";
    ticks(2);
    wr(2'd3, 16'd9);
    chk("R10 preload ignored while running", int'(count), 3);
    wr(2'd1, 16'h0000);
    ticks(5);
    chk("R10 stopped holds", int'(count), 3);

    // R8 external source and latency
    cur_req = "R8";
    wr(2'd0, 16'd10);
    wr(2'd3, 16'd1);
    wr(2'd1, 16'h0005);
    ticks(5);
    chk("R8 internal ignored", int'(count), 1);
    ext_pin = 1'b1;
    idle(2);
    chk("R8 not yet", int'(count), 1);
    idle(1);
    chk("R8 after sync", int'(count), 2);

    // R9 edge selection
    cur_req = "R9";
    ext_pin = 1'b0;
    idle(4);
    chk("R9 rising ignores fall", int'(count), 2);
    wr(2'd1, 16'h0015);
    ext_pin = 1'b1;
    idle(4);
    chk("R9 falling ignores rise", int'(count), 2);
    ext_pin = 1'b0;
    idle(4);
    chk("R9 falling counts", int'(count), 3);
    wr(2'd1, 16'h000D);
    ext_pin = 1'b1;
    idle(4);
    chk("R9 both rise", int'(count), 4);
    ext_pin = 1'b0;
    idle(4);
    chk("R9 both fall", int'(count), 5);

    cur_req = "R2";
    idle(2);
    finish_run();
  end

endmodule